// File: doc/BRIEF.md
# Four-Channel Match Timer

This block is an operating-system timer for a memory-mapped peripheral space. A 32-bit up-counter advances once for every clock on which the tick input is high. Four compare channels each hold a 32-bit match value. When a tick arrives while the counter equals a channel's match value, that channel's sticky status flag is set. A per-channel enable decides whether the flag drives the shared interrupt line. Software removes a flag by writing 1 to it.

The counter, all match values and the enable mask can be read and written over a simple 32-bit register bus, so software can save and later restore the timer's full state. A watchdog control, which can only be switched on, routes channel 3 matches to a reset-request output. That output stays high until the next hardware reset.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all match values, the status flags, the enable mask and the watchdog control read as zero, and `irq` and `rst_req` are low.
- R2: On each clock edge with `tick` high and no counter write, the counter increments by one, wrapping from 0xFFFFFFFF to 0. With `tick` low it holds its value.
- R3: A bus write to offset 0x10 loads the counter at that clock edge. The write takes priority over a tick in the same cycle, and later matches use the loaded value.
- R4: A match event on channel n is a cycle with `tick` high in which the counter (its value before the edge) equals match value n. The event sets status bit n at that edge, whatever the enable mask holds.
- R5: The status flags read at offset 0x14 in bits 3:0, one bit per channel. Writing 1 to bit n clears flag n, and writing 0 leaves it alone. A match event in the same cycle as its clear wins, so the flag stays set.
- R6: The enable mask sits at offset 0x1C, bits 3:0. `irq` is high exactly when some channel has both its status flag and its enable bit set. Clearing an enable bit leaves the match value unchanged.
- R7: Match value n can be read and written as a full 32-bit value at byte offset 4·n (0x00, 0x04, 0x08, 0x0C).
- R8: Bit 0 of offset 0x18 is the watchdog control. Writing 1 sets it. Writing 0 never clears it, and only reset does. It reads back in bit 0.
- R9: A channel 3 match event that occurs while the watchdog control is already set raises `rst_req` at that edge. `rst_req` then stays high until reset. Matches on channels 0 to 2 never raise it.
- R10: Offsets at or above 0x20, and offsets that are not multiples of 4, read as zero, and writes to them change nothing.
- R11: `rdata` reflects the register selected by `addr` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Combined interrupt |
| rst_req | output | 1 | Watchdog reset request |

## Verification
The hardest situations to reach are a match that lands exactly on the counter wrap and a status clear that coincides with a new match on the same channel. The counter would need 2^32 ticks to get there on its own. The stimulus instead loads the counter a few counts short of the target and places match values at 0xFFFFFFFF and 0. It then writes all-ones to the status register on every cycle while ticking through those matches. The watchdog path is reached the same way, by loading channel 3 a few ticks ahead of the counter once the control bit is set, after a write of 0 has tried to clear it.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    RK_MATCH, RK_COUNT, RK_STATUS, RK_WDOG, RK_IEN, RK_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [1:0]       ch;
  } reg_sel_t;

  // Map a byte offset to a register kind; offsets outside 0x00..0x1C or
  // not word aligned map to RK_NONE.
  function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_t r;
    logic [IDX_W-1:0] idx;
    idx    = a[IDX_W+1:2];
    r.ch   = idx[1:0];
    r.kind = RK_NONE;
    if (a[1:0] == 2'b00 && a[ADDR_W-1:IDX_W+2] == '0) begin
      case (idx)
        3'd0, 3'd1, 3'd2, 3'd3: r.kind = RK_MATCH;
        3'd4:                   r.kind = RK_COUNT;
        3'd5:                   r.kind = RK_STATUS;
        3'd6:                   r.kind = RK_WDOG;
        default:                r.kind = RK_IEN;
      endcase
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] c);
    return c + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  // Flag update: events set, write-one clears, set wins
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr);
    return set_ev | (cur & ~clr);
  endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter
  import ostmr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= count + {{(W-1){1'b0}}, 1'b1};
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (count == $past(count) + 1'b1));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/ostmr_channel.sv
module ostmr_channel
  import ostmr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         wr_match,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] match_val,
  output logic         evt,
  output logic         status
);
  assign evt = tick && (count == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_val <= '0;
      status    <= 1'b0;
    end else begin
      if (wr_match) match_val <= wdata;
      status <= flag_next(status, evt, clr);
    end
  end

  // R4
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status);
  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(evt));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !status);
endmodule

// File: rtl/ostmr_regbus.sv
module ostmr_regbus
  import ostmr_pkg::*;
(
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  match_vals,
  input  logic [DATA_W-1:0]              count,
  input  logic [NUM_CH-1:0]              status,
  input  logic [NUM_CH-1:0]              ien,
  input  logic                           wdog_on,
  output logic [NUM_CH-1:0]              wr_match,
  output logic                           wr_count,
  output logic [NUM_CH-1:0]              clr,
  output logic                           wr_wdog,
  output logic                           wr_ien,
  output logic [DATA_W-1:0]              rdata
);
  reg_sel_t sel;
  assign sel = decode_offset(addr);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_wsel
    assign wr_match[n] = wr_en && sel.kind == RK_MATCH && sel.ch == n[1:0];
    assign clr[n]      = wr_en && sel.kind == RK_STATUS && wdata[n];
  end

  assign wr_count = wr_en && sel.kind == RK_COUNT;
  assign wr_wdog  = wr_en && sel.kind == RK_WDOG && wdata[0];
  assign wr_ien   = wr_en && sel.kind == RK_IEN;

  always_comb begin
    rdata = '0;
    case (sel.kind)
      RK_MATCH:  rdata = match_vals[sel.ch];
      RK_COUNT:  rdata = count;
      RK_STATUS: rdata[NUM_CH-1:0] = status;
      RK_WDOG:   rdata[0] = wdog_on;
      RK_IEN:    rdata[NUM_CH-1:0] = ien;
      default:   rdata = '0;
    endcase
  end

  // R10
  always_comb begin
    if (sel.kind == RK_NONE)
      unmapped_quiet_chk: assert (rdata == '0 && !wr_count && wr_match == '0
                                  && clr == '0 && !wr_wdog && !wr_ien);
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import ostmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int WDOG_CH = NUM_CH - 1;

  logic [DATA_W-1:0]             count;
  logic [NUM_CH-1:0][DATA_W-1:0] match_vals;
  logic [NUM_CH-1:0]             status, evt, clr, wr_match, ien;
  logic                          wr_count, wr_wdog, wr_ien, wdog_on;
  logic                          wdog_fire;

  ostmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(wr_count), .load_val(wdata), .count(count)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    ostmr_channel #(.W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
      .wr_match(wr_match[n]), .wdata(wdata), .clr(clr[n]),
      .match_val(match_vals[n]), .evt(evt[n]), .status(status[n])
    );
  end

  ostmr_regbus u_bus (
    .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .match_vals(match_vals), .count(count), .status(status),
    .ien(ien), .wdog_on(wdog_on),
    .wr_match(wr_match), .wr_count(wr_count), .clr(clr),
    .wr_wdog(wr_wdog), .wr_ien(wr_ien), .rdata(rdata)
  );

  assign wdog_fire = wdog_on && evt[WDOG_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      wdog_on <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_ien)    ien     <= wdata[NUM_CH-1:0];
      if (wr_wdog)   wdog_on <= 1'b1;
      if (wdog_fire) rst_req <= 1'b1;
    end
  end

  assign irq = |(status & ien);

  // R8
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_on |=> wdog_on);
  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R9
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(wdog_on) && $past(evt[WDOG_CH])));
  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/tb_os_match_timer.sv
module tb_os_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  os_match_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  bit [31:0] m_cnt;
  bit [31:0] m_mt [4];
  bit [3:0]  m_st, m_ie;
  bit        m_wd, m_rq;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a[1:0] != 0 || a >= 8'h20) return 0;
    case (a >> 2)
      0, 1, 2, 3: return m_mt[a >> 2];
      4: return m_cnt;
      5: return {28'd0, m_st};
      6: return {31'd0, m_wd};
      default: return {28'd0, m_ie};
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_ie = 0; m_wd = 0; m_rq = 0;
      foreach (m_mt[i]) m_mt[i] = 0;
    end else begin
      bit [3:0] ev;
      bit [3:0] cl;
      bit mapped;
      ev = 0; cl = 0;
      mapped = wr_en && addr[1:0] == 0 && addr < 8'h20;
      for (int i = 0; i < 4; i++) ev[i] = tick && (m_cnt == m_mt[i]);
      if (m_wd && ev[3]) m_rq = 1;
      if (mapped && addr == 8'h14) cl = wdata[3:0];
      m_st = ev | (m_st & ~cl);
      if (mapped && addr < 8'h10) m_mt[addr >> 2] = wdata;
      if (mapped && addr == 8'h1C) m_ie = wdata[3:0];
      if (mapped && addr == 8'h18 && wdata[0]) m_wd = 1;
      if (mapped && addr == 8'h10) m_cnt = wdata;
      else if (tick) m_cnt = m_cnt + 1;
    end
  end

  // per-cycle comparison of the registered outputs (R6, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 irq", {31'd0, irq}, {31'd0, |(m_st & m_ie)});
      check("R9 rst_req", {31'd0, rst_req}, {31'd0, m_rq});
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input bit [7:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 check(req, rdata, m_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) rd(req, 8'(i * 4));
  endtask

  initial begin
    #200000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    read_all("R1 reset");
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);

    // R7 match registers, R11 same-cycle read
    wr(8'h00, 32'hDEADBEEF); wr(8'h04, 32'h12345678);
    wr(8'h08, 32'h0F0F0F0F); wr(8'h0C, 32'hFFFFFFFF);
    read_all("R7 R11 match rw");

    // R2 counting with continuous ticks, R4 match without enable
    wr(8'h00, 32'd6);
    tick = 1'b1;
    idle(10);
    rd("R2 count", 8'h10);
    rd("R4 status without enable", 8'h14);
    // R6 enable raises irq, disable drops it, match kept
    wr(8'h1C, 32'h1);
    idle(2);
    wr(8'h1C, 32'h0);
    rd("R6 match kept", 8'h00);
    // R2 sparse ticks
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); tick = i[0] ^ i[2];
    end
    rd("R2 sparse ticks", 8'h10);
    tick = 1'b0;
    idle(3);
    rd("R2 hold", 8'h10);

    // R5 write 0 does nothing, write 1 clears
    wr(8'h14, 32'h0);
    rd("R5 write zero", 8'h14);
    wr(8'h1C, 32'hF);
    wr(8'h14, 32'h1);
    rd("R5 w1c", 8'h14);

    // R3 counter load near wrap, wrap match on ch1/ch2, set beats clear
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFFFFFC);
    rd("R3 load", 8'h10);
    tick = 1'b1;
    for (int i = 0; i < 8; i++) wr(8'h14, 32'hF);
    rd("R5 set wins over clear", 8'h14);
    rd("R2 wrap", 8'h10);
    // R3 load takes priority over tick
    wr(8'h10, 32'h100);
    rd("R3 load over tick", 8'h10);
    tick = 1'b0;
    wr(8'h14, 32'hF);
    rd("R5 clear all", 8'h14);

    // R10 unmapped
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h11, 32'hFFFFFFFF);
    wr(8'h1E, 32'hFFFFFFFF);
    rd("R10 read 0x20", 8'h20);
    rd("R10 read 0x11", 8'h11);
    rd("R10 read 0x1E", 8'h1E);
    read_all("R10 no side effect");

    // R9 channel 3 match before watchdog on: no reset request
    wr(8'h0C, 32'h103);
    tick = 1'b1;
    idle(6);
    tick = 1'b0;
    check("R9 no req when off", {31'd0, rst_req}, 32'd0);
    // R8 set, try to clear
    wr(8'h18, 32'h1);
    wr(8'h18, 32'h0);
    rd("R8 sticky", 8'h18);
    // R9 channels 0..2 do not fire reset
    wr(8'h00, 32'h10A); wr(8'h04, 32'h10B);
    wr(8'h0C, 32'h110);
    tick = 1'b1;
    idle(5);
    check("R9 other channels", {31'd0, rst_req}, 32'd0);
    idle(8);
    tick = 1'b0;
    idle(4);
    check("R9 req raised", {31'd0, rst_req}, 32'd1);
    rd("R9 status", 8'h14);

    // R1 reset again clears everything including watchdog
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    read_all("R1 second reset");
    check("R1 rst_req cleared", {31'd0, rst_req}, 32'd0);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule